// File: doc/BRIEF.md
# CRC Parallel-Matrix Row Generator

This block works out, one row per clock, the impulse-response matrix of a serial CRC shift register. Those rows are the raw material for a parallel CRC equation set. The generator polynomial is given at run time, without its highest-order term. The engine behaves like the serial LFSR:

- the register is cleared,
- a single 1 enters on the serial input in the first step,
- zeros enter in every step after that.

After each step the register state is shown as one matrix row. A row index and a valid strobe come with it.

A job is launched by a one-cycle start pulse. The polynomial and the number of rows are captured on that pulse. The rows then stream out on consecutive cycles, and a one-cycle done pulse marks the end of the job. A start seen while a job is running is dropped. The rows follow carry-less (XOR) long division. For the 5-bit polynomial x^5+x^2+1 (input value 5'b00101), the first four rows are 00101, 01010, 10100 and 01101.

Top module: `crc_matrix_rowgen`

## Requirements
- R1: While reset is high and after it, row_valid, done, row_index and row_value are all 0 until a job is started.
- R2: A start sampled while idle makes row_valid high on the next cycle, with row_index 0 and row_value equal to the polynomial input captured at that start. This is the register cleared to zero with a single 1 shifted in.
- R3: Each later row equals the previous row shifted left by one bit with a 0 entering bit 0. It is XORed with the captured polynomial only when bit W-1 of the previous row was 1. The combination is a carry-less XOR. For polynomial 5'b00101, rows 0 to 3 are 5'b00101, 5'b01010, 5'b10100, 5'b01101.
- R4: For a row count N greater than 0, row_valid stays high for exactly N consecutive cycles. During those cycles row_index runs 0, 1, ..., N-1.
- R5: done is high for exactly one cycle, namely the cycle right after the last valid row, and row_valid is low in that cycle.
- R6: A start while rows are still being produced is ignored, together with the polynomial and count presented with it. The running job's rows and length do not change.
- R7: Changes on poly_in and row_count after the start cycle have no effect on the running job.
- R8: A start with row count 0 produces no valid row. done pulses on the cycle after the start.
- R9: A start presented in the cycle where done is high is accepted. Row 0 of the new job appears on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that launches a job when idle |
| poly_in | input | W | Generator polynomial without its top-order bit |
| row_count | input | CNT_W | Number of rows to produce |
| row_value | output | W | Current matrix row |
| row_index | output | CNT_W | Index of the current row, from 0 |
| row_valid | output | 1 | High while row_value and row_index hold a row |
| done | output | 1 | One-cycle pulse after the last row |

## Verification
Two functions can fall in the same cycle: the end-of-job done pulse and the acceptance of a new start. The bench raises start in the very cycle where done is seen high. It then requires row 0 of the new polynomial on the next cycle, with index 0 and no second done. The opposite overlap is also exercised: a start with a different polynomial arrives while rows are still streaming. That job's rows must stay exactly those of its own polynomial, and its length must match its own count.

// File: rtl/crcmx_pkg.sv
package crcmx_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } crcmx_state_e;
endpackage

// File: rtl/crcmx_step.sv
// One step of the serial CRC register: shift left, feed back the polynomial
// when the outgoing bit XOR the serial input is 1.
module crcmx_step #(
    parameter int unsigned W = 5
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] poly,
    input  logic         din,
    output logic [W-1:0] nxt
);
    logic fb;
    assign fb = cur[W-1] ^ din;

    assign nxt[0] = fb & poly[0];
    for (genvar i = 1; i < W; i++) begin : g_bit
        assign nxt[i] = cur[i-1] ^ (fb & poly[i]);
    end
endmodule

// File: rtl/crcmx_seq.sv
// Job sequencer: accepts start when idle, walks the row index, ends with done.
module crcmx_seq
    import crcmx_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] row_count,
    output logic             accept,
    output logic             advance,
    output logic             busy,
    output logic             valid,
    output logic             done,
    output logic [CNT_W-1:0] index
);
    typedef struct packed {
        crcmx_state_e     st;
        logic [CNT_W-1:0] idx;
        logic [CNT_W-1:0] last;
        logic             valid;
        logic             done;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d       = seq_q;
        seq_d.valid = 1'b0;
        seq_d.done  = 1'b0;
        accept      = 1'b0;
        advance     = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    accept = 1'b1;
                    if (row_count == '0) begin
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.st    = ST_RUN;
                        seq_d.idx   = '0;
                        seq_d.last  = row_count - 1'b1;
                        seq_d.valid = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (seq_q.idx == seq_q.last) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                end else begin
                    seq_d.idx   = seq_q.idx + 1'b1;
                    seq_d.valid = 1'b1;
                    advance     = 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '{st: ST_IDLE, idx: '0, last: '0, valid: 1'b0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy  = (seq_q.st == ST_RUN);
    assign valid = seq_q.valid;
    assign done  = seq_q.done;
    assign index = seq_q.idx;

    // R4: consecutive rows carry consecutive indices
    a_r4_index_step: assert property (@(posedge clk) disable iff (rst)
        valid && $past(valid) |-> index == CNT_W'($past(index) + 1'b1));

    // R4: a fresh burst of rows starts at index 0
    a_r4_first_index: assert property (@(posedge clk) disable iff (rst)
        valid && !$past(valid) |-> index == '0);

    // R5: done never coincides with a valid row
    a_r5_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(valid && done));

    // R5 / R8: done only follows a last row or a zero-length start
    a_r5_done_cause: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(valid) || $past(accept));
endmodule

// File: rtl/crc_matrix_rowgen.sv
// Top: holds the captured polynomial and the row register.
module crc_matrix_rowgen
    import crcmx_pkg::*;
#(
    parameter int unsigned W     = 5,
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [W-1:0]     poly_in,
    input  logic [CNT_W-1:0] row_count,
    output logic [W-1:0]     row_value,
    output logic [CNT_W-1:0] row_index,
    output logic             row_valid,
    output logic             done
);
    typedef struct packed {
        logic [W-1:0] row;
        logic [W-1:0] poly;
    } dp_t;

    dp_t dp_d, dp_q;

    logic         accept, advance, busy;
    logic [W-1:0] step_cur, step_poly, step_nxt;
    logic         step_din;

    crcmx_seq #(.CNT_W(CNT_W)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .row_count (row_count),
        .accept    (accept),
        .advance   (advance),
        .busy      (busy),
        .valid     (row_valid),
        .done      (done),
        .index     (row_index)
    );

    crcmx_step #(.W(W)) step_i (
        .cur  (step_cur),
        .poly (step_poly),
        .din  (step_din),
        .nxt  (step_nxt)
    );

    always_comb begin
        // On acceptance the register is treated as cleared and the lone 1 enters.
        step_cur  = accept ? '0 : dp_q.row;
        step_poly = accept ? poly_in : dp_q.poly;
        step_din  = accept;

        dp_d = dp_q;
        if (accept) begin
            dp_d.poly = poly_in;
        end
        if (accept || advance) begin
            dp_d.row = step_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign row_value = dp_q.row;

    // R2: row 0 is the captured polynomial
    a_r2_first_row: assert property (@(posedge clk) disable iff (rst)
        row_valid && row_index == '0 |-> row_value == dp_q.poly);

    // R3: every later row follows from the previous one
    a_r3_row_step: assert property (@(posedge clk) disable iff (rst)
        row_valid && $past(row_valid) |->
            row_value == ({$past(row_value[W-2:0]), 1'b0} ^
                          ($past(row_value[W-1]) ? dp_q.poly : '0)));

    // R6 / R7: the captured polynomial holds while a job runs
    a_r6_poly_hold: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(dp_q.poly));
endmodule

// File: tb/crc_matrix_rowgen_tb_top.sv
module crc_matrix_rowgen_tb_top;
    localparam int unsigned W     = 5;
    localparam int unsigned CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [W-1:0]     poly_in = '0;
    logic [CNT_W-1:0] row_count = '0;
    logic [W-1:0]     row_value;
    logic [CNT_W-1:0] row_index;
    logic             row_valid;
    logic             done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    crc_matrix_rowgen #(.W(W), .CNT_W(CNT_W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .poly_in   (poly_in),
        .row_count (row_count),
        .row_value (row_value),
        .row_index (row_index),
        .row_valid (row_valid),
        .done      (done)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Independent model: serial register from zero, 1 then zeros on input.
    function automatic logic [W-1:0] exp_row(input logic [W-1:0] p, input int i);
        logic [W-1:0] r = '0;
        for (int k = 0; k <= i; k++) begin
            logic fb = r[W-1] ^ (k == 0);
            r = {r[W-2:0], 1'b0} ^ (fb ? p : '0);
        end
        return r;
    endfunction

    // Called at a negedge; pulses start for one cycle, then scrambles inputs (R7).
    task automatic launch(input logic [W-1:0] p, input logic [CNT_W-1:0] n);
        start = 1'b1; poly_in = p; row_count = n;
        @(negedge clk);
        start = 1'b0; poly_in = ~p; row_count = n + 8'd3;
    endtask

    // Checks a running job from row 0; optionally injects a start at row inj.
    task automatic follow(input string req, input logic [W-1:0] p, input int n,
                          input int inj, input bit chain);
        for (int i = 0; i < n; i++) begin
            if (i > 0) begin
                if (i == inj) begin
                    start = 1'b1; poly_in = 5'b11011; row_count = 8'd2;
                end
                @(negedge clk);
                start = 1'b0;
            end
            check(req, $sformatf("valid row %0d", i), 32'(row_valid), 32'd1);
            check(req, $sformatf("index row %0d", i), 32'(row_index), 32'(i));
            check(req, $sformatf("value row %0d", i), 32'(row_value), 32'(exp_row(p, i)));
        end
        @(negedge clk);
        check("R5", "done after last row", 32'(done), 32'd1);
        check("R5", "valid low at done", 32'(row_valid), 32'd0);
        if (!chain) begin
            @(negedge clk);
            check("R5", "done single pulse", 32'(done), 32'd0);
            check("R4", "valid stays low", 32'(row_valid), 32'd0);
        end
    endtask

    task automatic t_reset();
        check("R1", "valid in reset", 32'(row_valid), 32'd0);
        check("R1", "done in reset", 32'(done), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "valid after reset", 32'(row_valid), 32'd0);
        check("R1", "done after reset", 32'(done), 32'd0);
        check("R1", "index after reset", 32'(row_index), 32'd0);
        check("R1", "row after reset", 32'(row_value), 32'd0);
    endtask

    task automatic t_crc5_rows();
        launch(5'b00101, 8'd4);
        check("R2", "row0 literal", 32'(row_value), 32'h05);
        @(negedge clk); check("R3", "row1 literal", 32'(row_value), 32'h0A);
        @(negedge clk); check("R3", "row2 literal", 32'(row_value), 32'h14);
        @(negedge clk); check("R3", "row3 literal", 32'(row_value), 32'h0D);
        check("R4", "row3 index", 32'(row_index), 32'd3);
        @(negedge clk);
        check("R5", "done after 4 rows", 32'(done), 32'd1);
        @(negedge clk);
        check("R5", "done falls", 32'(done), 32'd0);
    endtask

    task automatic t_long_rows();
        launch(5'b00101, 8'd20);
        follow("R3", 5'b00101, 20, -1, 1'b0);
        launch(5'b10011, 8'd12);
        follow("R4", 5'b10011, 12, -1, 1'b0);
    endtask

    task automatic t_busy_start();
        launch(5'b01001, 8'd7);
        follow("R6", 5'b01001, 7, 3, 1'b0);
    endtask

    task automatic t_input_change();
        launch(5'b11111, 8'd5);
        poly_in = 5'b00001; row_count = 8'd1;
        follow("R7", 5'b11111, 5, -1, 1'b0);
    endtask

    task automatic t_zero_count();
        launch(5'b00101, 8'd0);
        check("R8", "no valid on zero count", 32'(row_valid), 32'd0);
        check("R8", "done on zero count", 32'(done), 32'd1);
        @(negedge clk);
        check("R8", "done falls", 32'(done), 32'd0);
        check("R8", "still no valid", 32'(row_valid), 32'd0);
    endtask

    task automatic t_back_to_back();
        launch(5'b00101, 8'd3);
        follow("R9", 5'b00101, 3, -1, 1'b1);
        launch(5'b10111, 8'd3);
        check("R9", "done not repeated", 32'(done), 32'd0);
        follow("R9", 5'b10111, 3, -1, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_crc5_rows();
        t_long_rows();
        t_busy_start();
        t_input_change();
        t_zero_count();
        t_back_to_back();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule